// File: doc/BRIEF.md
# Retriggerable Clearable One-Shot Timer

This block is a clocked monostable. When its gated trigger condition goes from false to true, it raises a pulse output for a fixed number of clock cycles, set by the parameter `WIDTH_CYCLES`. The gate has two active-low inputs and two active-high inputs. An active-low clear ends any pulse in progress. A true output and its complement are both provided. For example, a 10 µs pulse at a 200 MHz clock needs `WIDTH_CYCLES = 2000`.

A trigger that arrives while the pulse is high reloads the full interval. The pulse therefore ends `WIDTH_CYCLES` cycles after the latest trigger, and a burst of triggers gives one stretched pulse. Every input passes through a two-flop synchroniser, so the latency from a pin to the output is fixed.

The control is a three-state machine:
- `ST_IDLE`: the output is low and the counter is zero.
- `ST_ACTIVE`: the output is high and the down-counter is running.
- `ST_HOLD`: the synchronised clear is low.

The transitions are:
- fire (`ST_IDLE`→`ST_ACTIVE`, counter loaded to full width).
- retrigger (`ST_ACTIVE`→`ST_ACTIVE`, counter reloaded to full width).
- expire (`ST_ACTIVE`→`ST_IDLE`, taken when the counter is at 1 and no trigger is present).
- clear (any state→`ST_HOLD`).
- release (`ST_HOLD`→`ST_IDLE`, or `ST_HOLD`→`ST_ACTIVE` when a trigger edge coincides with the release).

Top module: `oneshot_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released until a trigger fires, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: The trigger condition is `(!gate_lo_a_n || !gate_lo_b_n) && gate_hi_a && gate_hi_b`. A pulse starts or restarts only on a cycle where this condition, as synchronised, goes from false to true. Holding the condition true does not restart the pulse.
- R3: Take an input value that is present at rising clock edge k. Its effect on the outputs appears after rising edge k+2: two cycles of synchronisation, then the state register. The trigger and the clear have the same latency.
- R4: With no further trigger and no clear, `pulse_o` stays high for exactly `WIDTH_CYCLES` clock cycles and then returns low.
- R5: A trigger that arrives after the previous pulse has ended starts a fresh pulse of exactly `WIDTH_CYCLES` cycles.
- R6: A trigger that arrives while `pulse_o` is high reloads the full width. The output stays high without a gap and falls `WIDTH_CYCLES` cycles after the new trigger takes effect.
- R7: When the synchronised `clear_n` is 0, the pulse ends on that edge and the counter goes to zero. Clear wins over a trigger in the same cycle. Triggers are ignored while clear is held low. A condition that is already true when clear is released does not fire.
- R8: `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_lo_a_n | input | 1 | First active-low trigger qualifier |
| gate_lo_b_n | input | 1 | Second active-low trigger qualifier |
| gate_hi_a | input | 1 | First active-high trigger qualifier |
| gate_hi_b | input | 1 | Second active-high trigger qualifier |
| clear_n | input | 1 | Active-low clear; keep it high for normal operation |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |

## Verification
The counter and the state register are visible at the ports with almost no delay, so a wrong internal state shows up quickly:
- A counter that reloads or steps wrongly moves the falling edge of `pulse_o` by at least one cycle. This shows within one pulse width of the trigger.
- A missed state change toward `ST_HOLD` or `ST_ACTIVE` shows as a wrong output level two cycles after the input edge.

The bench compares both outputs against a cycle model on every cycle. It also measures the delay to the rising edge and the length of each pulse in directed scenarios: a single trigger, a fresh trigger after timeout, a retrigger, and a clear during a pulse. A bias of even one cycle in the synchroniser or the counter is therefore seen on the first affected pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } os_state_e;

    // Bit positions inside the synchronised input vector
    localparam int IDX_CLR  = 4;
    localparam int IDX_LO_A = 3;
    localparam int IDX_LO_B = 2;
    localparam int IDX_HI_A = 1;
    localparam int IDX_HI_B = 0;
    localparam int NUM_IN   = 5;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int N_BITS = 5,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] din,
    output logic [N_BITS-1:0] dout
);
    logic [STAGES-1:0][N_BITS-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] sync_in,
    output logic              clr_ok,
    output logic              trig
);
    logic [1:0] lo_act;
    logic       any_lo;
    logic       cond_now;
    logic       cond_prev;

    // One enable term per active-low qualifier
    generate
        for (genvar g = 0; g < 2; g++) begin : g_lo
            assign lo_act[g] = ~sync_in[IDX_LO_B + g];
        end
    endgenerate

    assign any_lo   = |lo_act;
    assign cond_now = any_lo & sync_in[IDX_HI_A] & sync_in[IDX_HI_B];
    assign clr_ok   = sync_in[IDX_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_prev <= 1'b0;
        else        cond_prev <= cond_now;
    end

    assign trig = cond_now & ~cond_prev;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R2
endmodule

// File: rtl/oneshot_fsm.sv
module oneshot_fsm
    import oneshot_pkg::*;
#(
    parameter int WIDTH_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_ok,
    input  logic trig,
    output logic pulse,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(WIDTH_CYCLES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH_CYCLES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    os_state_e        state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    // Next-state and counter logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (!clr_ok) begin
                    nxt_state = ST_HOLD;   // clear
                    nxt_cnt   = '0;
                end else if (trig) begin
                    nxt_state = ST_ACTIVE; // fire
                    nxt_cnt   = FULL;
                end
            end
            ST_ACTIVE: begin
                if (!clr_ok) begin
                    nxt_state = ST_HOLD;   // clear
                    nxt_cnt   = '0;
                end else if (trig) begin
                    nxt_cnt   = FULL;      // retrigger
                end else if (cnt == ONE) begin
                    nxt_state = ST_IDLE;   // expire
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt   = cnt - ONE;
                end
            end
            ST_HOLD: begin
                if (clr_ok) begin
                    if (trig) begin
                        nxt_state = ST_ACTIVE;
                        nxt_cnt   = FULL;
                    end else begin
                        nxt_state = ST_IDLE; // release
                    end
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Outputs
    always_comb begin
        pulse   = (state == ST_ACTIVE);
        pulse_n = ~pulse;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |=> (state == ST_HOLD && cnt == '0)); // R7
    AST_FULL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && trig) |=> (state == ST_ACTIVE && cnt == FULL)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !trig && state == ST_ACTIVE && cnt > ONE) |=> (cnt == $past(cnt) - ONE)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> (cnt == '0)); // R4
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_lo_a_n,
    input  logic gate_lo_b_n,
    input  logic gate_hi_a,
    input  logic gate_hi_b,
    input  logic clear_n,
    output logic pulse_o,
    output logic pulse_n_o
);
    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] sync_in;
    logic              clr_ok;
    logic              trig;

    always_comb begin
        raw_in           = '0;
        raw_in[IDX_CLR]  = clear_n;
        raw_in[IDX_LO_A] = gate_lo_a_n;
        raw_in[IDX_LO_B] = gate_lo_b_n;
        raw_in[IDX_HI_A] = gate_hi_a;
        raw_in[IDX_HI_B] = gate_hi_b;
    end

    oneshot_sync #(.N_BITS(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    oneshot_trig u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_in(sync_in),
        .clr_ok (clr_ok),
        .trig   (trig)
    );

    oneshot_fsm #(.WIDTH_CYCLES(WIDTH_CYCLES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_ok (clr_ok),
        .trig   (trig),
        .pulse  (pulse_o),
        .pulse_n(pulse_n_o)
    );
endmodule

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;
    localparam int W = 40;

    typedef struct packed {
        logic clr_n;
        logic lo_a_n;
        logic lo_b_n;
        logic hi_a;
        logic hi_b;
    } in_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_lo_a_n = 1'b0, gate_lo_b_n = 1'b0, gate_hi_a = 1'b0, gate_hi_b = 1'b0, clear_n = 1'b0;
    logic pulse_o, pulse_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    in_t cur_in = '0;
    in_t p1 = '0, p2 = '0, p3 = '0;
    int  m_cnt = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    oneshot_timer #(.WIDTH_CYCLES(W)) u_oneshot_timer (
        .clk(clk), .rst_n(rst_n),
        .gate_lo_a_n(gate_lo_a_n), .gate_lo_b_n(gate_lo_b_n),
        .gate_hi_a(gate_hi_a), .gate_hi_b(gate_hi_b),
        .clear_n(clear_n),
        .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    function automatic bit cond_of(input in_t x);   // R2
        return (!x.lo_a_n || !x.lo_b_n) && x.hi_a && x.hi_b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at negedge, advance model at posedge, compare after it
    task automatic tick(input in_t x);
        string tag;
        bit c, cp;
        @(negedge clk);
        cur_in = x;
        clear_n = x.clr_n; gate_lo_a_n = x.lo_a_n; gate_lo_b_n = x.lo_b_n;
        gate_hi_a = x.hi_a; gate_hi_b = x.hi_b;
        @(posedge clk);
        c  = cond_of(p2);   // R3: two cycles of synchroniser latency
        cp = cond_of(p3);
        if (!p2.clr_n) begin
            m_cnt = 0; tag = "R7";
        end else if (c && !cp) begin
            tag = (m_cnt > 0) ? "R6" : "R5";
            m_cnt = W;
        end else begin
            if (m_cnt > 0) m_cnt--;
            tag = c ? "R2" : "R4";
        end
        p3 = p2; p2 = p1; p1 = x;
        #1;
        check(tag, int'(pulse_o), int'(m_cnt != 0));
        check("R8", int'(pulse_n_o), int'(m_cnt == 0));
    endtask

    task automatic wait_level(input logic lvl, input int max_t, output int n);
        n = 0;
        while (pulse_o !== lvl && n < max_t) begin
            tick(cur_in);
            n++;
        end
    endtask

    function automatic in_t mk(input bit clr_n, input bit hi_a);
        in_t r;
        r.clr_n = clr_n; r.lo_a_n = 1'b0; r.lo_b_n = 1'b0; r.hi_a = hi_a; r.hi_b = 1'b1;
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int n;
        in_t x;
        repeat (4) @(posedge clk);
        #1;
        check("R1", int'(pulse_o), 0);
        check("R1", int'(pulse_n_o), 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) tick(mk(1'b1, 1'b0));
        check("R1", int'(pulse_o), 0);

        // Single trigger: rising gate_hi_a, held high afterwards
        tick(mk(1'b1, 1'b1));
        wait_level(1'b1, 10, n);
        check("R3", n, 2);
        wait_level(1'b0, 3 * W, n);
        check("R4", n, W);          // also R2: level held true did not restart
        tick(mk(1'b1, 1'b0));
        for (int i = 0; i < 10; i++) tick(mk(1'b1, 1'b0));

        // Fresh trigger after timeout
        tick(mk(1'b1, 1'b1));
        wait_level(1'b1, 10, n);
        check("R5", n, 2);
        wait_level(1'b0, 3 * W, n);
        check("R5", n, W);
        for (int i = 0; i < 10; i++) tick(mk(1'b1, 1'b0));

        // Retrigger while active
        tick(mk(1'b1, 1'b1));
        wait_level(1'b1, 10, n);
        check("R3", n, 2);
        for (int i = 0; i < 3; i++) tick(mk(1'b1, 1'b0));
        tick(mk(1'b1, 1'b1));
        check("R6", int'(pulse_o), 1);
        wait_level(1'b0, 3 * W, n);
        check("R6", n, W + 2);
        for (int i = 0; i < 10; i++) tick(mk(1'b1, 1'b0));

        // Clear during an active pulse
        tick(mk(1'b1, 1'b1));
        wait_level(1'b1, 10, n);
        for (int i = 0; i < 5; i++) tick(mk(1'b1, 1'b1));
        tick(mk(1'b0, 1'b1));
        wait_level(1'b0, 10, n);
        check("R7", n, 2);
        tick(mk(1'b0, 1'b0));
        tick(mk(1'b0, 1'b1));       // edge while clear held: ignored
        for (int i = 0; i < 6; i++) tick(mk(1'b0, 1'b1));
        check("R7", int'(pulse_o), 0);
        for (int i = 0; i < 8; i++) tick(mk(1'b1, 1'b1));  // release with level true
        check("R7", int'(pulse_o), 0);
        tick(mk(1'b1, 1'b0));
        tick(mk(1'b1, 1'b1));
        wait_level(1'b1, 10, n);
        check("R5", n, 2);

        // Constrained random phase
        void'($urandom(32'h5EED_0122));
        x = cur_in;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) begin
                case ($urandom_range(3))
                    0: x.lo_a_n = ~x.lo_a_n;
                    1: x.lo_b_n = ~x.lo_b_n;
                    2: x.hi_a   = ~x.hi_a;
                    default: x.hi_b = ~x.hi_b;
                endcase
            end
            if (x.clr_n) begin
                if ($urandom_range(149) == 0) x.clr_n = 1'b0;
            end else if ($urandom_range(3) == 0) begin
                x.clr_n = 1'b1;
            end
            tick(x);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule